// File: doc/BRIEF.md
# Display Mode Register Sanitizer

This block is the register port of a linear-framebuffer display-mode controller. A host first writes a register index and then a 16-bit value. The block never refuses a value. It stores what the host wrote. While the mode is switched on, a multi-cycle repair engine then moves every mode register to the nearest value that fits the framebuffer, and it derives the figures the scan-out logic needs: the line pitch in bytes, the largest usable row count, and the scan start address in 32-bit words.

The repair runs as a short state machine. It legalises depth and widths in one cycle. A restoring divider computes the row limit. Then it clamps the vertical resolution and the pan offsets. The last step checks that the visible window fits, dropping first the vertical pan and then the horizontal pan if it does not. While this runs the block reports busy and holds off the host. A read port returns the register chosen by the index, or the framebuffer size in 64 KiB units.

Top module: `disp_mode_regs`

## Requirements
- R1: While the enable bit (bit 0 of the control register, index 3) is clear, data writes are stored exactly as written and no repair starts (busy stays low).
- R2: Depth (index 2) values 4, 8, 16, 24 and 32 are kept and used as written. The value 15 is kept in the register but counts as 16 bits for byte arithmetic. Any other value is rewritten to 8.
- R3: Horizontal resolution (index 0) is rounded down to a multiple of 8. A result of 0 becomes 8, and the value is limited to MAX_X.
- R4: Virtual width (index 4) is rounded down to a multiple of 8 and limited to MAX_X. It is then raised to the horizontal resolution if it is smaller.
- R5: The pitch output equals virtual width × effective bits ÷ 8. The read-only virtual height (index 5) equals FB_BYTES ÷ pitch, saturated to 16 bits.
- R6: Vertical resolution (index 1) of 0 becomes 1. It is then limited to MAX_Y and after that to the virtual height.
- R7: X offset (index 6) is limited to MAX_X and Y offset (index 7) to MAX_Y. The byte offset is floor(X × bits ÷ 8) + Y × pitch, and the start output is the byte offset ÷ 4, rounded down.
- R8: If the byte offset plus vertical resolution × pitch exceeds FB_BYTES, Y offset is set to 0 and the test is repeated. If it still overflows, X offset is also set to 0 and the offset is 0.
- R9: Setting the enable bit while it is clear stores the control value, clears virtual width and both offsets, and then runs the full repair.
- R10: Reading index 8 returns FB_BYTES ÷ 65536.
- R11: A data write that starts a repair makes busy high from the next cycle until the outputs are valid. wr_ready is low while busy, and any write offered then is dropped.
- R12: rd_data shows the register at the current index. Indices with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, taken when wr_ready is high |
| wr_sel_data | input | 1 | 0: write the index, 1: write the data at the index |
| wr_data | input | 16 | Index or data value |
| wr_ready | output | 1 | High when a write is accepted |
| rd_data | output | 16 | Value at the current index |
| busy | output | 1 | Repair in progress |
| pitch_bytes | output | 32 | Line pitch in bytes |
| start_word | output | 32 | Scan start address in 32-bit words |

## Verification
Whenever the mode is enabled and idle, the assertions check on every cycle that the resolutions and virtual width sit inside their legal ranges and that the visible window ends inside the framebuffer. They also check that each divider result is the exact quotient, that storage is raw while the mode is disabled, and that busy follows every trigger. The exact repaired values can only be shown by the bench's scenarios. These include the depth rewrite, the 15-bit depth arithmetic, the pitch and row limit, the offset arithmetic with its floor at 4 bits per pixel, the two-step pan fallback, the clearing done on enable, and the dropping of writes while busy.

// File: rtl/disp_mode_pkg.sv
package disp_mode_pkg;

    localparam int unsigned RW = 16;

    typedef enum logic [3:0] {
        IX_HRES    = 4'd0,
        IX_VRES    = 4'd1,
        IX_DEPTH   = 4'd2,
        IX_CTRL    = 4'd3,
        IX_VWIDTH  = 4'd4,
        IX_VHEIGHT = 4'd5,
        IX_XOFF    = 4'd6,
        IX_YOFF    = 4'd7,
        IX_MEMSZ   = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic [RW-1:0] hres;
        logic [RW-1:0] vres;
        logic [RW-1:0] depth;
        logic [RW-1:0] ctrl;
        logic [RW-1:0] vwidth;
        logic [RW-1:0] vheight;
        logic [RW-1:0] xoff;
        logic [RW-1:0] yoff;
    } mode_regs_t;

    typedef enum logic [2:0] {
        FX_IDLE, FX_CLAMP, FX_DIV, FX_VRES, FX_OFFS
    } fix_state_e;

    function automatic logic [5:0] eff_bits(input logic [RW-1:0] d);
        case (d)
            16'd4, 16'd8, 16'd16, 16'd24, 16'd32: eff_bits = d[5:0];
            16'd15:                               eff_bits = 6'd16;
            default:                              eff_bits = 6'd8;
        endcase
    endfunction

    function automatic logic [RW-1:0] fix_depth(input logic [RW-1:0] d);
        case (d)
            16'd4, 16'd8, 16'd15, 16'd16, 16'd24, 16'd32: fix_depth = d;
            default:                                      fix_depth = 16'd8;
        endcase
    endfunction

    function automatic logic [RW-1:0] cap(input logic [RW-1:0] v, input logic [RW-1:0] lim);
        cap = (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/disp_divu.sv
module disp_divu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, den_q, num_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted, diff;

    always_comb begin
        shifted = {rem_q, quo[W-1]};
        diff    = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0; done <= 1'b0; cnt <= '0;
            rem_q <= '0; quo <= '0; den_q <= '0; num_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0; quo <= num; num_q <= num; den_q <= den;
                cnt <= CW'(W); run <= 1'b1;
            end else if (run) begin
                if (!diff[W]) begin
                    rem_q <= diff[W-1:0];
                    quo   <= {quo[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo   <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R5: the row limit is the exact quotient
    p_quotient_exact_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ((2*W)'(quo) * (2*W)'(den_q) <= (2*W)'(num_q)) &&
                 ((2*W)'(num_q) < ((2*W)'(quo) + 1) * (2*W)'(den_q)));
endmodule

// File: rtl/disp_fixup.sv
module disp_fixup
    import disp_mode_pkg::*;
#(
    parameter int          MAX_X    = 1600,
    parameter int          MAX_Y    = 1200,
    parameter logic [31:0] FB_BYTES = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  mode_regs_t  regs_i,
    output logic        wb_en_o,
    output mode_regs_t  wb_o,
    output logic        busy_o,
    output logic [31:0] pitch_o,
    output logic [31:0] start_word_o
);
    localparam logic [RW-1:0] MX = RW'(MAX_X);
    localparam logic [RW-1:0] MY = RW'(MAX_Y);
    localparam int SW = 48;

    fix_state_e  st;
    logic [31:0] line_q, maxy_q, line_c, quo;
    logic        div_done;
    mode_regs_t  clamp_c, vres_c, offs_c;
    logic [5:0]  bits_c;
    logic [SW-1:0] xb, off_a, span, off_fin;

    // stage 1: depth, horizontal resolution, virtual width
    always_comb begin
        logic [RW-1:0] h, vw;
        clamp_c       = regs_i;
        clamp_c.depth = fix_depth(regs_i.depth);
        h = regs_i.hres & ~16'h7;
        if (h == '0) h = 16'd8;
        h  = cap(h, MX);
        vw = cap(regs_i.vwidth & ~16'h7, MX);
        if (vw < h) vw = h;
        clamp_c.hres   = h;
        clamp_c.vwidth = vw;
        line_c = (32'(vw) * 32'(eff_bits(clamp_c.depth))) >> 3;
    end

    // stage 2: vertical resolution, row limit, offset limits
    always_comb begin
        logic [RW-1:0] v;
        vres_c = regs_i;
        v = (regs_i.vres == '0) ? 16'd1 : regs_i.vres;
        v = cap(v, MY);
        if (32'(v) > maxy_q) v = maxy_q[RW-1:0];
        vres_c.vres    = v;
        vres_c.vheight = (maxy_q > 32'hFFFF) ? 16'hFFFF : maxy_q[RW-1:0];
        vres_c.xoff    = cap(regs_i.xoff, MX);
        vres_c.yoff    = cap(regs_i.yoff, MY);
    end

    // stage 3: window fit with pan fallback
    always_comb begin
        bits_c = eff_bits(regs_i.depth);
        offs_c = regs_i;
        xb     = (SW'(regs_i.xoff) * SW'(bits_c)) >> 3;
        off_a  = xb + SW'(regs_i.yoff) * SW'(line_q);
        span   = SW'(regs_i.vres) * SW'(line_q);
        off_fin = off_a;
        if (off_a + span > SW'(FB_BYTES)) begin
            offs_c.yoff = '0;
            off_fin     = xb;
            if (xb + span > SW'(FB_BYTES)) begin
                offs_c.xoff = '0;
                off_fin     = '0;
            end
        end
    end

    disp_divu #(.W(32)) u_div (
        .clk(clk), .rst(rst), .start(st == FX_CLAMP),
        .num(FB_BYTES), .den(line_c), .done(div_done), .quo(quo)
    );

    always_comb begin
        wb_en_o = 1'b0;
        wb_o    = regs_i;
        case (st)
            FX_CLAMP: begin wb_en_o = 1'b1; wb_o = clamp_c; end
            FX_VRES:  begin wb_en_o = 1'b1; wb_o = vres_c;  end
            FX_OFFS:  begin wb_en_o = 1'b1; wb_o = offs_c;  end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FX_IDLE; line_q <= '0; maxy_q <= '0;
            pitch_o <= '0; start_word_o <= '0;
        end else begin
            case (st)
                FX_IDLE:  if (start_i) st <= FX_CLAMP;
                FX_CLAMP: begin line_q <= line_c; st <= FX_DIV; end
                FX_DIV:   if (div_done) begin maxy_q <= quo; st <= FX_VRES; end
                FX_VRES:  st <= FX_OFFS;
                FX_OFFS: begin
                    pitch_o      <= line_q;
                    start_word_o <= 32'(off_fin >> 2);
                    st           <= FX_IDLE;
                end
                default:  st <= FX_IDLE;
            endcase
        end
    end

    assign busy_o = (st != FX_IDLE);
endmodule

// File: rtl/disp_mode_regs.sv
module disp_mode_regs
    import disp_mode_pkg::*;
#(
    parameter int          MAX_X    = 1600,
    parameter int          MAX_Y    = 1200,
    parameter logic [31:0] FB_BYTES = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel_data,
    input  logic [15:0] wr_data,
    output logic        wr_ready,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic [31:0] pitch_bytes,
    output logic [31:0] start_word
);
    localparam logic [15:0] MEM_UNITS = 16'(FB_BYTES >> 16);

    mode_regs_t regs, wb;
    logic [3:0] idx;
    logic       wb_en, take, data_wr, kick, is_mode_reg;

    assign wr_ready = !busy;
    assign take     = wr_en && wr_ready;
    assign data_wr  = take && wr_sel_data;

    always_comb begin
        case (idx)
            IX_HRES, IX_VRES, IX_DEPTH, IX_VWIDTH, IX_XOFF, IX_YOFF: is_mode_reg = 1'b1;
            default: is_mode_reg = 1'b0;
        endcase
        kick = data_wr && ((is_mode_reg && regs.ctrl[0]) ||
                           (idx == IX_CTRL && wr_data[0] && !regs.ctrl[0]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
            idx  <= '0;
        end else if (wb_en) begin
            regs <= wb;
        end else if (take && !wr_sel_data) begin
            idx <= wr_data[3:0];
        end else if (data_wr) begin
            case (idx)
                IX_HRES:   regs.hres   <= wr_data;
                IX_VRES:   regs.vres   <= wr_data;
                IX_DEPTH:  regs.depth  <= wr_data;
                IX_VWIDTH: regs.vwidth <= wr_data;
                IX_XOFF:   regs.xoff   <= wr_data;
                IX_YOFF:   regs.yoff   <= wr_data;
                IX_CTRL: begin
                    regs.ctrl <= wr_data;
                    if (wr_data[0] && !regs.ctrl[0]) begin
                        regs.vwidth <= '0;
                        regs.xoff   <= '0;
                        regs.yoff   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IX_HRES:    rd_data = regs.hres;
            IX_VRES:    rd_data = regs.vres;
            IX_DEPTH:   rd_data = regs.depth;
            IX_CTRL:    rd_data = regs.ctrl;
            IX_VWIDTH:  rd_data = regs.vwidth;
            IX_VHEIGHT: rd_data = regs.vheight;
            IX_XOFF:    rd_data = regs.xoff;
            IX_YOFF:    rd_data = regs.yoff;
            IX_MEMSZ:   rd_data = MEM_UNITS;
            default:    rd_data = '0;
        endcase
    end

    disp_fixup #(.MAX_X(MAX_X), .MAX_Y(MAX_Y), .FB_BYTES(FB_BYTES)) u_fix (
        .clk(clk), .rst(rst), .start_i(kick), .regs_i(regs),
        .wb_en_o(wb_en), .wb_o(wb), .busy_o(busy),
        .pitch_o(pitch_bytes), .start_word_o(start_word)
    );

    // R1: raw storage while disabled
    p_store_raw_r1: assert property (@(posedge clk) disable iff (rst)
        (data_wr && idx == IX_HRES && !regs.ctrl[0]) |=> (regs.hres == $past(wr_data)) && !busy);
    // R3
    p_hres_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && regs.ctrl[0]) |-> (regs.hres[2:0] == 3'd0) && (regs.hres != '0) &&
                                    (32'(regs.hres) <= 32'(MAX_X)));
    // R4
    p_vwidth_cover_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && regs.ctrl[0]) |-> (regs.vwidth >= regs.hres) && (regs.vwidth[2:0] == 3'd0) &&
                                    (32'(regs.vwidth) <= 32'(MAX_X)));
    // R6
    p_vres_range_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && regs.ctrl[0]) |-> (regs.vres != '0) && (32'(regs.vres) <= 32'(MAX_Y)) &&
                                    (regs.vres <= regs.vheight));
    // R8
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && regs.ctrl[0]) |-> (64'(start_word) * 64'd4 + 64'(regs.vres) * 64'(pitch_bytes)
                                     <= 64'(FB_BYTES)));
    // R11
    p_busy_after_kick_r11: assert property (@(posedge clk) disable iff (rst)
        kick |=> busy);
endmodule

// File: tb/sim_disp_mode_regs.sv
module sim_disp_mode_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel_data = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready, busy;
    logic [15:0] rd_data;
    logic [31:0] pitch_bytes, start_word;

    int n_chk = 0, n_fail = 0, cyc = 0;

    localparam logic [15:0] I_HRES = 0, I_VRES = 1, I_DEPTH = 2, I_CTRL = 3,
                            I_VW = 4, I_VH = 5, I_X = 6, I_Y = 7, I_MEM = 8;

    // inputs: depth,hres,vres,vw,x,y | expected: depth,hres,vres,vw,vh,x,y,pitch,start
    localparam int VEC [0:5][0:14] = '{
        '{ 8,  640,  480,  800,   16,   10,   8,  640,  480,  800, 1310,   16, 10,  800, 2004},
        '{15, 1023,    0,    5, 3000, 5000,  15, 1016,    1, 1016,  516, 1600,  0, 2032,  800},
        '{ 7, 2000, 1300, 1700,  100,    1,   8, 1600,  655, 1600,  655,  100,  0, 1600,   25},
        '{32,    0, 1200, 1024, 1000,    3,  32,    8,  256, 1024,  256,    0,  0, 4096,    0},
        '{ 4, 1280, 1024, 1280,    9,    7,   4, 1280, 1024, 1280, 1638,    9,  7,  640, 1121},
        '{24,  800,  600,  800,    0,    2,  24,  800,  436,  800,  436,    0,  0, 2400,    0}
    };

    disp_mode_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel_data(wr_sel_data), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_data(rd_data), .busy(busy),
        .pitch_bytes(pitch_bytes), .start_word(start_word)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hw(input logic sel, input logic [15:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_en = 1'b1; wr_sel_data = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle;
        while (busy) @(negedge clk);
    endtask

    task automatic put(input logic [15:0] ix, input logic [15:0] v);
        hw(1'b0, ix); hw(1'b1, v); settle();
    endtask

    task automatic get(input logic [15:0] ix, output int v);
        hw(1'b0, ix); v = int'(rd_data);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", int'(busy), 0);
        chk("R5 reset pitch", int'(pitch_bytes), 0);
        chk("R7 reset start", int'(start_word), 0);
        chk("R12 reset hres", int'(rd_data), 0);

        get(I_MEM, v); chk("R10 memory size", v, 16);
        get(4'd12, v); chk("R12 unused index", v, 0);

        for (int i = 0; i < 6; i++) begin
            put(I_CTRL, 16'd0);
            put(I_DEPTH, 16'(VEC[i][0]));
            put(I_HRES, 16'(VEC[i][1]));
            chk("R1 no busy when disabled", int'(busy), 0);
            put(I_VRES, 16'(VEC[i][2]));
            get(I_DEPTH, v); chk("R1 raw depth", v, VEC[i][0]);
            get(I_HRES, v);  chk("R1 raw hres", v, VEC[i][1]);
            put(I_CTRL, 16'd1);
            get(I_VW, v); chk("R9 vwidth after enable", v, VEC[i][7]);
            get(I_X, v);  chk("R9 xoff cleared", v, 0);
            put(I_VW, 16'(VEC[i][3]));
            put(I_X, 16'(VEC[i][4]));
            put(I_Y, 16'(VEC[i][5]));
            get(I_DEPTH, v); chk("R2 depth", v, VEC[i][6]);
            get(I_HRES, v);  chk("R3 hres", v, VEC[i][7]);
            get(I_VRES, v);  chk("R6 vres", v, VEC[i][8]);
            get(I_VW, v);    chk("R4 vwidth", v, VEC[i][9]);
            get(I_VH, v);    chk("R5 vheight", v, VEC[i][10]);
            get(I_X, v);     chk("R7 xoff", v, VEC[i][11]);
            get(I_Y, v);     chk("R8 yoff", v, VEC[i][12]);
            chk("R5 pitch", int'(pitch_bytes), VEC[i][13]);
            chk("R7 start word", int'(start_word), VEC[i][14]);
        end

        // R11: busy timing and dropped write while busy (mode enabled here)
        hw(1'b0, I_HRES);
        @(negedge clk);
        wr_en = 1'b1; wr_sel_data = 1'b1; wr_data = 16'd640;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 busy next cycle", int'(busy), 1);
        chk("R11 ready low", int'(wr_ready), 0);
        wr_en = 1'b1; wr_sel_data = 1'b1; wr_data = 16'd16;
        @(negedge clk);
        wr_en = 1'b0;
        settle();
        get(I_HRES, v); chk("R11 write while busy dropped", v, 640);

        // R1: disabled write of an illegal width keeps it raw
        put(I_CTRL, 16'd0);
        put(I_HRES, 16'd13);
        get(I_HRES, v); chk("R1 raw odd hres", v, 13);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule